// File: doc/BRIEF.md
# SDRAM Burst Engine With Clock Suspend

This block models the column-burst side of a synchronous DRAM device. It takes registered commands on a small command bus, runs a read or write burst over a programmable number of columns, and writes into or reads from a small internal data array. Bursts step through columns in order and wrap inside a block aligned to the burst length.

The block also models clock-enable sampling. When clock enable is seen low while a burst is running, the device skips the next internal clock edge. The burst position holds, commands and write data on the pins are ignored, and read data already on the output stays driven. When clock enable is seen low while no burst is running, the edge is still ignored, but the suspend indication stays low.

Top module: `sdr_burst_engine`

## Requirements
- R1: A synchronous active-high reset clears `wr_stb_o`, `rd_oe_o`, `susp_o`, `int_bank_o` and `int_col_o` to zero and sets the burst length to 1. Reset does not clear the data array.
- R2: Commands are encoded on `cmd_i` as 2'b00 no-op, 2'b01 write, 2'b10 read and 2'b11 set-length. Set-length takes `col_i[1:0]` as a length code: 0 means 1 beat, 1 means 2, 2 means 4 and 3 means 8. The new length applies to bursts that start afterwards.
- R3: On the clock after each effective write beat, `wr_stb_o` is 1 and `int_bank_o`/`int_col_o` show the location written. The write data for a beat is the `wdata_i` value present at that beat's edge, starting with the edge that carries the write command.
- R4: A read command produces one beat per effective edge. On the clock after each beat, `rd_oe_o` is 1 and `rd_data_o` holds the array word at the `int_bank_o`/`int_col_o` shown.
- R5: Beat k of a burst of length L that starts at column c uses column (c with its low log2(L) bits replaced by (c + k) mod L).
- R6: If clock enable is sampled low at edge T while a burst is in progress, edge T+1 is suspended. No beat occurs, command and data inputs are ignored, `wr_stb_o` is 0, `susp_o` is 1 on the following clock, and `rd_data_o`, `rd_oe_o`, `int_bank_o` and `int_col_o` keep their values.
- R7: After clock enable is sampled high again, the burst resumes on the next edge at the beat where it stopped.
- R8: If clock enable is sampled low while no burst is in progress, the next edge is ignored: a command on it has no effect, no strobe appears, and `susp_o` stays 0.
- R9: A burst ends after the programmed number of unsuspended beats. `rd_oe_o` drops on the next effective edge that has no new read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Clock enable, sampled on each rising edge |
| cmd_i | input | 2 | Command code (R2) |
| bank_i | input | BANK_W | Bank for a read or write command |
| col_i | input | COL_W | Start column, or length code for set-length |
| wdata_i | input | DATA_W | Write data for the current beat |
| wr_stb_o | output | 1 | Array write strobe of the last edge |
| int_bank_o | output | BANK_W | Bank of the last beat |
| int_col_o | output | COL_W | Internal column of the last beat |
| rd_data_o | output | DATA_W | Read data |
| rd_oe_o | output | 1 | Read data drive enable |
| susp_o | output | 1 | Last edge was suspended during a burst |

## Verification
Write bursts of length 4 and 8 start at columns away from the block boundary, so a wrong wrap rule, such as counting past the boundary or restarting at the base, shows up as a wrong column. A length-4 read is suspended for two edges in a row, with a write command and new data on the pins during the second suspended edge; this separates a correct freeze from designs that advance the counter, accept the command or drop the drive enable. A separate pattern drives clock enable low between bursts with a write on the masked edge, which tells a correct idle skip apart from a false suspend flag or a stray strobe. Length-1 and length-2 reads, and a reset in the middle of a burst, check that the drive enable ends on time.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_READ  = 2'b10,
    CMD_SETBL = 2'b11
  } cmd_e;

  localparam int BL_CODE_W = 2;
  localparam int IDX_W     = 3;
endpackage

// File: rtl/sdr_cke_gate.sv
module sdr_cke_gate (
  input  logic clk,
  input  logic rst,
  input  logic cke_i,
  input  logic burst_on_i,
  output logic tick_o,
  output logic susp_o
);
  logic cke_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q  <= 1'b1;
      susp_o <= 1'b0;
    end else begin
      cke_q  <= cke_i;
      susp_o <= !cke_q && burst_on_i;
    end
  end

  // internal edge happens only when clock enable was seen high one edge earlier
  assign tick_o = cke_q && !rst;

  // R6: a suspend flag needs clock enable low two edges back
  a_r6_susp_needs_low_cke: assert property (@(posedge clk) disable iff (rst)
    susp_o |-> !$past(cke_i, 2));
endmodule

// File: rtl/sdr_burst_ctrl.sv
module sdr_burst_ctrl
  import sdr_burst_pkg::*;
#(
  parameter int COL_W  = 6,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  output logic              beat_vld_o,
  output logic              beat_wr_o,
  output logic [BANK_W-1:0] beat_bank_o,
  output logic [COL_W-1:0]  beat_col_o,
  output logic              burst_on_o
);
  cmd_e cmd;
  assign cmd = cmd_e'(cmd_i);

  logic                 on_q, wr_q;
  logic [BANK_W-1:0]    bank_q;
  logic [COL_W-1:0]     base_q;
  logic [IDX_W-1:0]     idx_q;
  logic [BL_CODE_W-1:0] len_q, blc_q;
  logic [IDX_W-1:0]     last_idx;
  logic                 start, cont;

  function automatic logic [COL_W-1:0] wrap_col(input logic [COL_W-1:0] s,
                                                input logic [IDX_W-1:0] i,
                                                input logic [BL_CODE_W-1:0] code);
    logic [COL_W-1:0] m;
    m = COL_W'((1 << code) - 1);
    return (s & ~m) | ((s + COL_W'(i)) & m);
  endfunction

  assign last_idx = IDX_W'((1 << len_q) - 1);
  assign start    = tick_i && (cmd == CMD_WRITE || cmd == CMD_READ);
  assign cont     = tick_i && on_q && !start;

  always_comb begin
    beat_vld_o = start || cont;
    if (start) begin
      beat_wr_o   = (cmd == CMD_WRITE);
      beat_bank_o = bank_i;
      beat_col_o  = col_i;
    end else begin
      beat_wr_o   = wr_q;
      beat_bank_o = bank_q;
      beat_col_o  = wrap_col(base_q, idx_q, len_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q   <= 1'b0;
      wr_q   <= 1'b0;
      bank_q <= '0;
      base_q <= '0;
      idx_q  <= '0;
      len_q  <= '0;
      blc_q  <= '0;
    end else if (tick_i) begin
      if (start) begin
        on_q   <= (blc_q != '0);
        wr_q   <= (cmd == CMD_WRITE);
        bank_q <= bank_i;
        base_q <= col_i;
        idx_q  <= IDX_W'(1);
        len_q  <= blc_q;
      end else if (on_q) begin
        idx_q <= idx_q + 1'b1;
        on_q  <= (idx_q != last_idx);
      end
      if (cmd == CMD_SETBL) blc_q <= col_i[BL_CODE_W-1:0];
    end
  end

  assign burst_on_o = on_q;

  // R9: a running burst never goes past its programmed length
  a_r9_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    on_q |-> (idx_q != '0 && idx_q <= last_idx));
  // R5: beat columns stay within the length-aligned block of the start column
  a_r5_wrap_in_block: assert property (@(posedge clk) disable iff (rst)
    cont |-> ((beat_col_o & ~COL_W'((1 << len_q) - 1)) == (base_q & ~COL_W'((1 << len_q) - 1))));
endmodule

// File: rtl/sdr_beat_array.sv
module sdr_beat_array #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // registered read with enable: output holds while no read beat occurs
  always_ff @(posedge clk) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/sdr_burst_engine.sv
module sdr_burst_engine #(
  parameter int DATA_W = 16,
  parameter int COL_W  = 6,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke_i,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wr_stb_o,
  output logic [BANK_W-1:0] int_bank_o,
  output logic [COL_W-1:0]  int_col_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_oe_o,
  output logic              susp_o
);
  localparam int ADDR_W = BANK_W + COL_W;

  logic              tick, burst_on;
  logic              beat_vld, beat_wr;
  logic [BANK_W-1:0] beat_bank;
  logic [COL_W-1:0]  beat_col;

  sdr_cke_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .cke_i      (cke_i),
    .burst_on_i (burst_on),
    .tick_o     (tick),
    .susp_o     (susp_o)
  );

  sdr_burst_ctrl #(.COL_W(COL_W), .BANK_W(BANK_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick),
    .cmd_i       (cmd_i),
    .bank_i      (bank_i),
    .col_i       (col_i),
    .beat_vld_o  (beat_vld),
    .beat_wr_o   (beat_wr),
    .beat_bank_o (beat_bank),
    .beat_col_o  (beat_col),
    .burst_on_o  (burst_on)
  );

  sdr_beat_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk     (clk),
    .we_i    (beat_vld && beat_wr),
    .waddr_i ({beat_bank, beat_col}),
    .wdata_i (wdata_i),
    .re_i    (beat_vld && !beat_wr),
    .raddr_i ({beat_bank, beat_col}),
    .rdata_o (rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb_o   <= 1'b0;
      rd_oe_o    <= 1'b0;
      int_bank_o <= '0;
      int_col_o  <= '0;
    end else if (tick) begin
      wr_stb_o <= beat_vld && beat_wr;
      rd_oe_o  <= beat_vld && !beat_wr;
      if (beat_vld) begin
        int_bank_o <= beat_bank;
        int_col_o  <= beat_col;
      end
    end else begin
      wr_stb_o <= 1'b0;
    end
  end

  // R6: read output, drive enable and address freeze across a suspended edge
  a_r6_hold_in_suspend: assert property (@(posedge clk) disable iff (rst)
    susp_o |-> ($stable(rd_data_o) && $stable(rd_oe_o) && $stable(int_col_o) && $stable(int_bank_o)));
  // R6: no array write on a suspended edge
  a_r6_no_strobe_in_suspend: assert property (@(posedge clk) disable iff (rst)
    susp_o |-> !wr_stb_o);
  // R4: read drive and write strobe never overlap
  a_r4_oe_write_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb_o && rd_oe_o));
  // R9: the drive enable only drops on an effective edge
  a_r9_oe_drop_unsuspended: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_oe_o) |-> !susp_o);
endmodule

// File: tb/sdr_burst_engine_tb.sv
module sdr_burst_engine_tb_top;
  localparam int DATA_W = 16;
  localparam int COL_W  = 6;
  localparam int BANK_W = 2;

  localparam logic [1:0] NOP = 2'b00, WR = 2'b01, RD = 2'b10, SB = 2'b11;

  typedef struct packed {
    logic        cke;
    logic [1:0]  cmd;
    logic [1:0]  bank;
    logic [5:0]  col;
    logic [15:0] wd;
    logic        e_ws;
    logic        e_oe;
    logic        e_su;
    logic [1:0]  e_bank;
    logic [5:0]  e_col;
    logic [15:0] e_rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{1'b1, SB,  2'd0, 6'd2,  16'h0000, 1'b0, 1'b0, 1'b0, 2'd0, 6'd0,  16'h0000, 4'd2}, // R2 length 4
    '{1'b1, WR,  2'd1, 6'd6,  16'h0011, 1'b1, 1'b0, 1'b0, 2'd1, 6'd6,  16'h0000, 4'd3}, // R3
    '{1'b0, NOP, 2'd0, 6'd0,  16'h0022, 1'b1, 1'b0, 1'b0, 2'd1, 6'd7,  16'h0000, 4'd3},
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0099, 1'b0, 1'b0, 1'b1, 2'd1, 6'd7,  16'h0000, 4'd6}, // R6 frozen write
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0033, 1'b1, 1'b0, 1'b0, 2'd1, 6'd4,  16'h0000, 4'd7}, // R7 resume, wrap
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0044, 1'b1, 1'b0, 1'b0, 2'd1, 6'd5,  16'h0000, 4'd5}, // R5
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 2'd1, 6'd5,  16'h0000, 4'd9}, // R9
    '{1'b1, RD,  2'd1, 6'd5,  16'h0000, 1'b0, 1'b1, 1'b0, 2'd1, 6'd5,  16'h0044, 4'd4}, // R4
    '{1'b0, NOP, 2'd0, 6'd0,  16'h0000, 1'b0, 1'b1, 1'b0, 2'd1, 6'd6,  16'h0011, 4'd4},
    '{1'b0, NOP, 2'd0, 6'd0,  16'h0000, 1'b0, 1'b1, 1'b1, 2'd1, 6'd6,  16'h0011, 4'd6}, // R6 read held
    '{1'b1, WR,  2'd0, 6'd0,  16'h0077, 1'b0, 1'b1, 1'b1, 2'd1, 6'd6,  16'h0011, 4'd6}, // R6 command ignored
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0000, 1'b0, 1'b1, 1'b0, 2'd1, 6'd7,  16'h0022, 4'd7}, // R7
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0000, 1'b0, 1'b1, 1'b0, 2'd1, 6'd4,  16'h0033, 4'd5},
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 2'd1, 6'd4,  16'h0000, 4'd9}, // R9 oe drops
    '{1'b0, NOP, 2'd0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 2'd1, 6'd4,  16'h0000, 4'd8}, // R8
    '{1'b1, WR,  2'd2, 6'd3,  16'h0055, 1'b0, 1'b0, 1'b0, 2'd1, 6'd4,  16'h0000, 4'd8}, // R8 masked write
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 2'd1, 6'd4,  16'h0000, 4'd8},
    '{1'b1, SB,  2'd0, 6'd3,  16'h0000, 1'b0, 1'b0, 1'b0, 2'd1, 6'd4,  16'h0000, 4'd2}, // R2 length 8
    '{1'b1, WR,  2'd3, 6'd13, 16'h0001, 1'b1, 1'b0, 1'b0, 2'd3, 6'd13, 16'h0000, 4'd3},
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0002, 1'b1, 1'b0, 1'b0, 2'd3, 6'd14, 16'h0000, 4'd5},
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0003, 1'b1, 1'b0, 1'b0, 2'd3, 6'd15, 16'h0000, 4'd5},
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0004, 1'b1, 1'b0, 1'b0, 2'd3, 6'd8,  16'h0000, 4'd5}, // R5 wrap
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0005, 1'b1, 1'b0, 1'b0, 2'd3, 6'd9,  16'h0000, 4'd5},
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0006, 1'b1, 1'b0, 1'b0, 2'd3, 6'd10, 16'h0000, 4'd5},
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0007, 1'b1, 1'b0, 1'b0, 2'd3, 6'd11, 16'h0000, 4'd5},
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0008, 1'b1, 1'b0, 1'b0, 2'd3, 6'd12, 16'h0000, 4'd5},
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 2'd3, 6'd12, 16'h0000, 4'd9},
    '{1'b1, SB,  2'd0, 6'd1,  16'h0000, 1'b0, 1'b0, 1'b0, 2'd3, 6'd12, 16'h0000, 4'd2}, // R2 length 2
    '{1'b1, RD,  2'd3, 6'd15, 16'h0000, 1'b0, 1'b1, 1'b0, 2'd3, 6'd15, 16'h0003, 4'd4},
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0000, 1'b0, 1'b1, 1'b0, 2'd3, 6'd14, 16'h0002, 4'd5},
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 2'd3, 6'd14, 16'h0000, 4'd9},
    '{1'b1, SB,  2'd0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 2'd3, 6'd14, 16'h0000, 4'd2}, // R2 length 1
    '{1'b1, RD,  2'd1, 6'd4,  16'h0000, 1'b0, 1'b1, 1'b0, 2'd1, 6'd4,  16'h0033, 4'd4},
    '{1'b1, NOP, 2'd0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 2'd1, 6'd4,  16'h0000, 4'd9}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              cke_i;
  logic [1:0]        cmd_i;
  logic [BANK_W-1:0] bank_i;
  logic [COL_W-1:0]  col_i;
  logic [DATA_W-1:0] wdata_i;
  logic              wr_stb_o, rd_oe_o, susp_o;
  logic [BANK_W-1:0] int_bank_o;
  logic [COL_W-1:0]  int_col_o;
  logic [DATA_W-1:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sdr_burst_engine #(.DATA_W(DATA_W), .COL_W(COL_W), .BANK_W(BANK_W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .cke_i      (cke_i),
    .cmd_i      (cmd_i),
    .bank_i     (bank_i),
    .col_i      (col_i),
    .wdata_i    (wdata_i),
    .wr_stb_o   (wr_stb_o),
    .int_bank_o (int_bank_o),
    .int_col_o  (int_col_o),
    .rd_data_o  (rd_data_o),
    .rd_oe_o    (rd_oe_o),
    .susp_o     (susp_o)
  );

  task automatic drive(input logic cke, input logic [1:0] cmd, input logic [1:0] bank,
                       input logic [5:0] col, input logic [15:0] wd);
    cke_i = cke; cmd_i = cmd; bank_i = bank; col_i = col; wdata_i = wd;
  endtask

  // rd_data_o is compared only while the drive enable is expected high
  task automatic check(input logic ws, input logic oe, input logic su, input logic [1:0] bk,
                       input logic [5:0] cl, input logic [15:0] rd, input int req);
    logic ok;
    n_chk++;
    ok = (wr_stb_o === ws) && (rd_oe_o === oe) && (susp_o === su) &&
         (int_bank_o === bk) && (int_col_o === cl) && (!oe || rd_data_o === rd);
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d at %0t: got ws=%b oe=%b su=%b bank=%0d col=%0d rd=%h, expected ws=%b oe=%b su=%b bank=%0d col=%0d rd=%h",
               req, $time, wr_stb_o, rd_oe_o, susp_o, int_bank_o, int_col_o, rd_data_o,
               ws, oe, su, bk, cl, rd);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(1'b1, NOP, 2'd0, 6'd0, 16'h0);
    @(negedge clk);
    repeat (3) step();
    rst = 1'b0;
    // R1: reset state
    check(1'b0, 1'b0, 1'b0, 2'd0, 6'd0, 16'h0, 1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].cke, VEC[i].cmd, VEC[i].bank, VEC[i].col, VEC[i].wd);
      step();
      check(VEC[i].e_ws, VEC[i].e_oe, VEC[i].e_su, VEC[i].e_bank, VEC[i].e_col, VEC[i].e_rd,
            int'(VEC[i].req));
    end

    // R1: reset in the middle of a length-8 write burst
    drive(1'b1, SB, 2'd0, 6'd3, 16'h0); step();
    drive(1'b1, WR, 2'd0, 6'd0, 16'h00AB); step();
    check(1'b1, 1'b0, 1'b0, 2'd0, 6'd0, 16'h0, 3);
    drive(1'b1, NOP, 2'd0, 6'd0, 16'h00CD); step();
    rst = 1'b1;
    drive(1'b1, NOP, 2'd0, 6'd0, 16'h00EE); step();
    rst = 1'b0;
    check(1'b0, 1'b0, 1'b0, 2'd0, 6'd0, 16'h0, 1);
    // R1: no burst continues after reset
    drive(1'b1, NOP, 2'd0, 6'd0, 16'h0); step();
    check(1'b0, 1'b0, 1'b0, 2'd0, 6'd0, 16'h0, 1);
    // R1: length back to 1, array kept
    drive(1'b1, RD, 2'd1, 6'd6, 16'h0); step();
    check(1'b0, 1'b1, 1'b0, 2'd1, 6'd6, 16'h0011, 1);
    drive(1'b1, RD, 2'd0, 6'd0, 16'h0); step();
    check(1'b0, 1'b1, 1'b0, 2'd0, 6'd0, 16'h00AB, 3);
    drive(1'b1, RD, 2'd0, 6'd1, 16'h0); step();
    check(1'b0, 1'b1, 1'b0, 2'd0, 6'd1, 16'h00CD, 3);
    drive(1'b1, NOP, 2'd0, 6'd0, 16'h0); step();
    check(1'b0, 1'b0, 1'b0, 2'd0, 6'd1, 16'h0, 1);

    // R8: clock enable low right after a length-1 write: strobe cleared, no suspend
    drive(1'b1, WR, 2'd2, 6'd9, 16'h0066); step();
    check(1'b1, 1'b0, 1'b0, 2'd2, 6'd9, 16'h0, 3);
    drive(1'b0, NOP, 2'd0, 6'd0, 16'h0); step();
    check(1'b0, 1'b0, 1'b0, 2'd2, 6'd9, 16'h0, 8);
    drive(1'b1, RD, 2'd2, 6'd9, 16'h0); step();
    check(1'b0, 1'b0, 1'b0, 2'd2, 6'd9, 16'h0, 8);
    drive(1'b1, RD, 2'd2, 6'd9, 16'h0); step();
    check(1'b0, 1'b1, 1'b0, 2'd2, 6'd9, 16'h0066, 4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule